// File: doc/BRIEF.md
# Programmable SD Card Clock Generator

This block derives the clock sent to an SD card from the host reference clock. Software writes a single control word over a write-only port. The word holds a one-hot divisor field, a pass-through bit, a divide-by-1024 extension bit, a clock enable bit and an idle auto-stop bit. The generator decodes these bits into one ratio and drives the card clock from a half-period counter. It starts, stops and changes rate only at points where no shortened pulse can reach the card.

Software clears the enable bit before it changes the divisor, then sets the bit again. The ratio is latched only while the clock is stopped, so a new divisor written while the clock runs waits for the next restart. When auto-stop is on, the clock also halts while the bus-idle input is high. It resumes within one divided period after the input falls. A status output shows whether the card clock is currently toggling.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, `card_clk` is low and `clk_running` is 0.
- R2: With only bit n (0..7) of the divisor field `cfg_wdata[7:0]` set and the enable bit `cfg_wdata[8]` set, `card_clk` divides the reference by 2^(n+2). Each high and low phase then lasts 2^(n+1) reference cycles.
- R3: With the enable bit set and no divisor or extension bit set, the ratio is 2, giving one reference cycle high and one low.
- R4: Bit 10 selects pass-through. While enabled, `card_clk` follows the reference clock (high in its high phase, low in its low phase).
- R5: Bit 16 selects divide by 1024 (512 cycles high, 512 low) when parameter `EXT_EN` is 1. When `EXT_EN` is 0 the bit is ignored and the ratio comes from the remaining bits.
- R6: When several selection bits are set, bit 10 wins over bit 16, and bit 16 wins over the divisor field. Within the field, the highest set bit decides.
- R7: A new ratio written while the clock runs has no effect on `card_clk` until the clock has stopped and been restarted.
- R8: Clearing the enable bit stops `card_clk` low. A low phase that has begun is always completed to its full length first.
- R9: With auto-stop (bit 9) set, `card_clk` stops low while `bus_idle` is 1. It rises again within one divided period after `bus_idle` falls. With bit 9 clear, `bus_idle` has no effect.
- R10: `clk_running` is 1 exactly while the card clock is being toggled, and 0 once it has stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | DATA_W | Control word (fields as in R2..R9) |
| bus_idle | input | 1 | High when no command or data transfer is active |
| card_clk | output | 1 | Clock to the card |
| clk_running | output | 1 | Card clock is toggling |

## Verification
The hardest case to reach from the ports is a divisor write that lands while the clock keeps running. Because the enable bit is never cleared, the new value must stay invisible until a full stop and restart. The bench writes a much slower divisor with the enable still set and measures an unchanged period. It then forces a stop and confirms that the slower period appears. Two instances, with and without the extension, receive the same writes, so every divisor combination is checked for both variants against half-periods computed as powers of two.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   // Control word bit positions (behaviour depends on these)
   localparam int EN_POS    = 8;
   localparam int AUTO_POS  = 9;
   localparam int BYP_POS   = 10;
   localparam int X1024_POS = 16;
   localparam int FIELD_MAX = 8;

   typedef struct packed {
      logic       en;
      logic       auto_stop;
      logic       byp;
      logic       x1024;
      logic [FIELD_MAX-1:0] div;
   } sdclk_cfg_t;
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
   import sdclk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output sdclk_cfg_t        cfg
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[DATA_W-1:X1024_POS+1], wdata[X1024_POS-1:BYP_POS+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         cfg.en        <= wdata[EN_POS];
         cfg.auto_stop <= wdata[AUTO_POS];
         cfg.byp       <= wdata[BYP_POS];
         cfg.x1024     <= wdata[X1024_POS];
         cfg.div       <= wdata[FIELD_MAX-1:0];
      end
   end
endmodule

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec #(
   parameter int DIV_BITS = 8,
   parameter bit EXT_EN   = 1'b1,
   localparam int HX_W    = $clog2(DIV_BITS + 2)
) (
   input  logic [DIV_BITS-1:0] div,
   input  logic                byp,
   input  logic                x1024,
   output logic                byp_sel,
   output logic [HX_W-1:0]     hexp
);
   logic ext_hit;

   generate
      if (EXT_EN) begin : g_ext
         assign ext_hit = x1024;
      end else begin : g_noext
         logic unused_x1024;
         assign unused_x1024 = x1024;
         assign ext_hit = 1'b0;
      end
   endgenerate

   // half period = 2^hexp reference cycles; highest field bit wins
   always_comb begin
      hexp = '0;
      for (int i = 0; i < DIV_BITS; i++) begin
         if (div[i]) hexp = HX_W'(i + 1);
      end
      if (ext_hit) hexp = HX_W'(DIV_BITS + 1);
      byp_sel = byp;
   end
endmodule

// File: rtl/sdclk_core.sv
module sdclk_core #(
   parameter int HX_W  = 4,
   parameter int CNT_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            want,
   input  logic            dec_byp,
   input  logic [HX_W-1:0] dec_hexp,
   output logic            card_clk,
   output logic            running
);
   logic             div_q;
   logic             byp_act;
   logic             gate_l;
   logic [HX_W-1:0]  hexp;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = ~({CNT_W{1'b1}} << hexp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         div_q   <= 1'b0;
         byp_act <= 1'b0;
         hexp    <= '0;
         cnt     <= '0;
      end else if (!running) begin
         cnt   <= '0;
         div_q <= 1'b0;
         if (want && !gate_l) begin
            running <= 1'b1;
            byp_act <= dec_byp;
            hexp    <= dec_hexp;
         end
      end else if (byp_act) begin
         if (!want) running <= 1'b0;
      end else if (cnt == last) begin
         cnt <= '0;
         if (div_q)     div_q   <= 1'b0;
         else if (want) div_q   <= 1'b1;
         else           running <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // pass-through gate changes only in the low phase of the reference
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_l <= 1'b0;
      else        gate_l <= running & byp_act;
   end

   assign card_clk = byp_act ? (clk & gate_l) : div_q;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DIV_BITS = 8,
   parameter bit EXT_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              bus_idle,
   output logic              card_clk,
   output logic              clk_running
);
   localparam int HX_W  = $clog2(DIV_BITS + 2);
   localparam int CNT_W = DIV_BITS + 1;

   generate
      if (DIV_BITS < 1 || DIV_BITS > FIELD_MAX) begin : g_bad_div
         $error("DIV_BITS must be 1..%0d", FIELD_MAX);
      end
      if (DATA_W <= X1024_POS + 1) begin : g_bad_w
         $error("DATA_W too small for control word");
      end
   endgenerate

   sdclk_cfg_t      cfg;
   logic            dec_byp;
   logic [HX_W-1:0] dec_hexp;
   logic            want;

   sdclk_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   logic unused_hi_div;
   generate
      if (DIV_BITS < FIELD_MAX) begin : g_trim
         assign unused_hi_div = ^cfg.div[FIELD_MAX-1:DIV_BITS];
      end else begin : g_full
         assign unused_hi_div = 1'b0;
      end
   endgenerate

   sdclk_ratio_dec #(.DIV_BITS(DIV_BITS), .EXT_EN(EXT_EN)) u_dec (
      .div     (cfg.div[DIV_BITS-1:0]),
      .byp     (cfg.byp),
      .x1024   (cfg.x1024),
      .byp_sel (dec_byp),
      .hexp    (dec_hexp)
   );

   assign want = cfg.en & ~(cfg.auto_stop & bus_idle);

   sdclk_core #(.HX_W(HX_W), .CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want),
      .dec_byp  (dec_byp),
      .dec_hexp (dec_hexp),
      .card_clk (card_clk),
      .running  (clk_running)
   );
endmodule

// File: rtl/sdclk_core_chk.sv
module sdclk_core_chk #(
   parameter int HX_W  = 4,
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             want,
   input logic             running,
   input logic             div_q,
   input logic             byp_act,
   input logic [HX_W-1:0]  hexp,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] last
);
   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt <= last);

   // R7
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) |-> $stable(hexp) && $stable(byp_act));

   // R8
   stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !div_q);

   // R8
   full_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) && !byp_act |-> !$past(div_q) && $past(cnt) == $past(last));

   // R9
   rise_needs_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_q) |-> $past(want));
endmodule

bind sdclk_core sdclk_core_chk #(.HX_W(HX_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .want    (want),
   .running (running),
   .div_q   (div_q),
   .byp_act (byp_act),
   .hexp    (hexp),
   .cnt     (cnt),
   .last    (last)
);

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;
   localparam int EN   = 1 << 8;
   localparam int AUTO = 1 << 9;
   localparam int BYP  = 1 << 10;
   localparam int X1K  = 1 << 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic        idle = 1'b0;
   logic [31:0] wd = '0;
   logic        card_clk, run, card_clk_b, run_b;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sdclk_gen #(.EXT_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd),
      .bus_idle(idle), .card_clk(card_clk), .clk_running(run));

   sdclk_gen #(.EXT_EN(1'b0)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd),
      .bus_idle(idle), .card_clk(card_clk_b), .clk_running(run_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); we = 1'b1; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   function automatic bit cur(input bit sel);
      return sel ? card_clk_b : card_clk;
   endfunction

   task automatic stop_all();
      wr(0);
      for (int g = 0; g < 3000; g++) begin
         if (!run && !run_b) break;
         @(negedge clk);
      end
      chk(!run && !run_b, "R8 stop", int'(run), 0);
   endtask

   task automatic measure(input bit sel, output int hi, output int lo);
      int g;
      g = 0;
      while (cur(sel) == 1'b1 && g < 5000) begin @(negedge clk); g++; end
      while (cur(sel) == 1'b0 && g < 5000) begin @(negedge clk); g++; end
      hi = 0;
      while (cur(sel) == 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
      lo = 0;
      while (cur(sel) == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
   endtask

   task automatic expect_half(input bit sel, input int h, input string req);
      int hi, lo;
      measure(sel, hi, lo);
      chk(hi == h, req, hi, h);
      chk(lo == h, req, lo, h);
   endtask

   task automatic run_cfg(input logic [31:0] d, input int ha, input int hb, input string req);
      stop_all();
      wr(d);
      expect_half(1'b0, ha, req);
      expect_half(1'b1, hb, req);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(card_clk == 1'b0 && card_clk_b == 1'b0, "R1 clk", int'(card_clk), 0);
      chk(run == 1'b0 && run_b == 1'b0, "R1 status", int'(run), 0);

      // R2 sweep of each one-hot field bit
      for (int n = 0; n < 8; n++) begin
         run_cfg(EN | (1 << n), 1 << (n + 1), 1 << (n + 1), "R2 onehot");
      end
      // R3 empty field
      run_cfg(EN, 1, 1, "R3 div2");
      // R5 extension: honoured / ignored
      run_cfg(EN | X1K, 512, 1, "R5 x1024");
      // R6 priorities
      run_cfg(EN | 32'h0A, 16, 16, "R6 field top");
      run_cfg(EN | X1K | 32'h04, 512, 8, "R6 ext over field");

      // R4 and R6 pass-through over everything
      stop_all();
      wr(EN | BYP | X1K | 32'h20);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #1;
         chk(card_clk && card_clk_b, "R4 bypass high", int'(card_clk), 1);
         @(negedge clk); #1;
         chk(!card_clk && !card_clk_b, "R4 bypass low", int'(card_clk), 0);
      end
      chk(run && run_b, "R10 bypass status", int'(run), 1);

      // R7 ratio written while running is ignored until restart
      run_cfg(EN | 32'h01, 2, 2, "R7 base");
      wr(EN | 32'h40);
      expect_half(1'b0, 2, "R7 ignored while running");
      run_cfg(EN | 32'h40, 128, 128, "R7 after restart");

      // R8 disable stops low; R10 status
      run_cfg(EN | 32'h02, 4, 4, "R8 base");
      chk(run == 1'b1, "R10 running", int'(run), 1);
      wr(0);
      repeat (10) @(negedge clk);
      chk(run == 1'b0, "R10 stopped", int'(run), 0);
      c = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); c += int'(card_clk); end
      chk(c == 0, "R8 held low", c, 0);

      // R9 auto-stop
      run_cfg(EN | AUTO | 32'h01, 2, 2, "R9 base");
      @(negedge clk); idle = 1'b1;
      repeat (8) @(negedge clk);
      chk(run == 1'b0, "R9 idle stop status", int'(run), 0);
      c = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); c += int'(card_clk); end
      chk(c == 0, "R9 idle low", c, 0);
      idle = 1'b0;
      c = 0;
      while (card_clk == 1'b0 && c < 100) begin @(negedge clk); c++; end
      chk(c <= 4, "R9 resume", c, 4);
      chk(run == 1'b1, "R10 resumed", int'(run), 1);
      // R9 without auto-stop, idle has no effect
      run_cfg(EN | 32'h01, 2, 2, "R9 base2");
      idle = 1'b1;
      expect_half(1'b0, 2, "R9 idle ignored");
      chk(run == 1'b1, "R9 status idle ignored", int'(run), 1);
      idle = 1'b0;

      finish_run();
   end
endmodule